// File: doc/BRIEF.md
# Scatter-Read Program Sequencer

This block keeps a small library of stored gather programs and runs one of them on command. A program is a list of fixed-size records, each naming a start address and a byte count. Running a program fetches, one byte at a time over a simple memory request port, every byte of every record in turn, and streams the fetched bytes out on a valid/ready byte port as one continuous run. Stored programs live in internal registers that stand in for non-volatile storage.

Programs arrive over a byte-wide load port as fixed-length frames. The loader totals the record counts while the frame streams in. It rejects a frame that carries a bad program number. It marks a program whose total is too large, and such a program is refused at run time. An empty program, whose first record is the terminator, finishes at once with no bytes and no error.

Top module: `scatter_read_seq`

## Requirements
- R1: Valid program numbers are 1 to 10. A load frame with any other number ends with ld_err = 1 and changes no stored program. A run request with any other number ends with ex_err = 1 and emits no byte.
- R2: A load frame is 104 bytes. Byte 0 comes with ld_sof high and its value is ignored. Byte 1 is the program number. Bytes 2 to 101 hold 25 records of four bytes each: address low, address high, count low, count high. Bytes 102 and 103 are a closing terminator and their values are ignored. ld_done pulses for one cycle in the cycle after the clock edge that accepts byte 103. ld_err is valid with that pulse: 0 means stored, 1 means bad number, 2 means too large.
- R3: A record whose start address is FFFFh ends the program, whatever its count. That record and every later slot add nothing to the size total and are never executed.
- R4: A run emits the bytes of each record from its start address upward, with records taken in slot order. A range that appears twice is emitted twice.
- R5: A program whose counts sum to at most 2048 is stored with ld_err = 0. A larger sum gives ld_err = 2, and a later run of that program gives ex_err = 2 and emits no byte.
- R6: A run of an empty program pulses ex_done with ex_err = 0 and emits no byte.
- R7: A record with count zero emits nothing and does not end the program.
- R8: After reset every program is empty, and ex_busy, ex_done, ld_done, mem_req and out_valid are low.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value.
- R10: Each emitted byte comes from exactly one memory request. mem_req and mem_addr hold steady until mem_rvalid, and only one request is outstanding at a time.
- R11: A later load of the same number replaces the program. A too-large reload makes a previously runnable program refuse to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load byte present |
| ld_sof | input | 1 | Marks the first byte of a load frame |
| ld_byte | input | 8 | Load frame byte |
| ld_done | output | 1 | One-cycle pulse at frame end |
| ld_err | output | 2 | Load result code, valid with ld_done |
| ex_start | input | 1 | Run request, taken when idle |
| ex_prog | input | 8 | Program number to run |
| ex_busy | output | 1 | Run in progress |
| ex_done | output | 1 | One-cycle pulse at run end |
| ex_err | output | 2 | Run result code, valid with ex_done: 0 ok, 1 bad number, 2 too large |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 8 | Read data byte |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Output byte accepted |

## Verification
The bench loads program numbers 0 and 11 and then reruns an earlier program. A design that let a bad number index storage would corrupt a neighbouring program or emit its bytes. It places a terminator carrying a nonzero count ahead of a large record. A design that counted past the terminator would flag a legal program as too large or emit the bytes that follow. It also loads totals of exactly 2048 and of 2049. An off-by-one size check would refuse the first total or run the second. Finally it runs programs with zero-count records, duplicate ranges and an empty list while out_ready stalls. A design that dropped or repeated a byte under backpressure, or that stopped at a zero count, would produce a stream of the wrong length or content.

// File: rtl/seqp_pkg.sv
package seqp_pkg;

  typedef struct packed {
    logic [15:0] cnt;
    logic [15:0] addr;
  } rec_t;

  localparam logic [1:0]  ERR_NONE  = 2'd0;
  localparam logic [1:0]  ERR_RANGE = 2'd1;
  localparam logic [1:0]  ERR_SIZE  = 2'd2;
  localparam logic [15:0] TERM_ADDR = 16'hFFFF;
  localparam int          SUMW      = 24;

  // program numbers count from one
  function automatic logic num_ok(input logic [7:0] n, input int nprog);
    return (n != 8'd0) && (int'(n) <= nprog);
  endfunction

  function automatic logic is_term(input rec_t r);
    return r.addr == TERM_ADDR;
  endfunction

  function automatic logic [SUMW-1:0] grow_total(input logic [SUMW-1:0] t, input rec_t r);
    return t + {{(SUMW-16){1'b0}}, r.cnt};
  endfunction

endpackage

// File: rtl/seqp_store.sv
module seqp_store
  import seqp_pkg::*;
#(
  parameter int NPROG = 10,
  parameter int NREC  = 25,
  localparam int PW = $clog2(NPROG),
  localparam int SW = $clog2(NREC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PW-1:0]    wr_prog,
  input  logic [SW-1:0]    wr_slot,
  input  rec_t             wr_rec,
  input  logic             ok_we,
  input  logic [PW-1:0]    ok_prog,
  input  logic             ok_val,
  input  logic [PW-1:0]    rd_prog,
  input  logic [SW-1:0]    rd_slot,
  output rec_t             rd_rec,
  output logic [NPROG-1:0] ok_vec
);

  localparam int DEPTH = NPROG * NREC;
  localparam int AW    = $clog2(DEPTH);

  function automatic logic [AW-1:0] flat(input logic [PW-1:0] p, input logic [SW-1:0] s);
    return AW'(p) * AW'(NREC) + AW'(s);
  endfunction

  rec_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_en) begin
      mem[flat(wr_prog, wr_slot)] <= wr_rec;
    end
  end

  logic rd_in_range;
  assign rd_in_range = (rd_slot < SW'(NREC)) && (rd_prog < PW'(NPROG));
  assign rd_rec      = rd_in_range ? mem[flat(rd_prog, rd_slot)] : '1;

  for (genvar gp = 0; gp < NPROG; gp++) begin : g_ok
    logic flag_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                             flag_q <= 1'b1;
      else if (ok_we && ok_prog == PW'(gp))   flag_q <= ok_val;
    end
    assign ok_vec[gp] = flag_q;
  end

  assert_wr_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || ok_we) |-> (wr_prog < PW'(NPROG)) && (ok_prog < PW'(NPROG)));

endmodule

// File: rtl/seqp_loader.sv
module seqp_loader
  import seqp_pkg::*;
#(
  parameter int NPROG     = 10,
  parameter int NREC      = 25,
  parameter int MAX_TOTAL = 2048,
  localparam int PW    = $clog2(NPROG),
  localparam int SW    = $clog2(NREC + 1),
  localparam int FRAME = 4 * NREC + 4,
  localparam int IW    = $clog2(FRAME + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic          ld_sof,
  input  logic [7:0]    ld_byte,
  output logic          wr_en,
  output logic [PW-1:0] wr_prog,
  output logic [SW-1:0] wr_slot,
  output rec_t          wr_rec,
  output logic          ok_we,
  output logic [PW-1:0] ok_prog,
  output logic          ok_val,
  output logic          ld_done,
  output logic [1:0]    ld_err
);

  logic            active;
  logic [IW-1:0]   idx;
  logic [7:0]      num_q;
  logic [23:0]     part;
  logic            term;
  logic [SUMW-1:0] total;

  logic [IW-1:0] rel;
  logic          in_recs, byte_take, rec_close, frame_end, num_good;
  rec_t          new_rec;

  assign rel       = idx - IW'(2);
  assign in_recs   = (idx >= IW'(2)) && (idx < IW'(2 + 4 * NREC));
  assign byte_take = ld_valid && active && !ld_sof;
  assign rec_close = byte_take && in_recs && (rel[1:0] == 2'd3);
  assign frame_end = byte_take && (idx == IW'(FRAME - 1));
  assign num_good  = num_ok(num_q, NPROG);
  assign new_rec   = '{cnt: {ld_byte, part[23:16]}, addr: part[15:0]};

  assign wr_en   = rec_close && num_good;
  assign wr_prog = PW'(num_q - 8'd1);
  assign wr_slot = SW'(rel >> 2);
  assign wr_rec  = new_rec;
  assign ok_we   = frame_end && num_good;
  assign ok_prog = PW'(num_q - 8'd1);
  assign ok_val  = total <= SUMW'(MAX_TOTAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      idx     <= '0;
      num_q   <= '0;
      part    <= '0;
      term    <= 1'b0;
      total   <= '0;
      ld_done <= 1'b0;
      ld_err  <= ERR_NONE;
    end else begin
      ld_done <= 1'b0;
      if (ld_valid && ld_sof) begin
        active <= 1'b1;
        idx    <= IW'(1);
        term   <= 1'b0;
        total  <= '0;
      end else if (byte_take) begin
        idx <= idx + IW'(1);
        if (idx == IW'(1)) num_q <= ld_byte;
        if (in_recs) begin
          case (rel[1:0])
            2'd0: part[7:0]   <= ld_byte;
            2'd1: part[15:8]  <= ld_byte;
            2'd2: part[23:16] <= ld_byte;
            default: begin
              if (!term) begin
                if (is_term(new_rec)) term  <= 1'b1;
                else                  total <= grow_total(total, new_rec);
              end
            end
          endcase
        end
        if (frame_end) begin
          active  <= 1'b0;
          ld_done <= 1'b1;
          ld_err  <= !num_good ? ERR_RANGE : (!ok_val ? ERR_SIZE : ERR_NONE);
        end
      end
    end
  end

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |=> !ld_done);

  assert_frame_ends_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |-> !active);

endmodule

// File: rtl/seqp_exec.sv
module seqp_exec
  import seqp_pkg::*;
#(
  parameter int NPROG     = 10,
  parameter int NREC      = 25,
  parameter int MAX_TOTAL = 2048,
  localparam int PW = $clog2(NPROG),
  localparam int SW = $clog2(NREC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       prog_num,
  input  logic [NPROG-1:0] ok_vec,
  output logic [PW-1:0]    rd_prog,
  output logic [SW-1:0]    rd_slot,
  input  rec_t             rec_in,
  output logic             mem_req,
  output logic [15:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [7:0]       mem_rdata,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err
);

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_REQ, S_SEND, S_DONE} st_t;

  st_t           st;
  logic [PW-1:0] prog_q;
  logic [SW-1:0] rec_q;
  logic [15:0]   cur_addr;
  logic [15:0]   left;
  logic [7:0]    byte_q;
  logic [1:0]    err_q;
  logic [15:0]   emitted;

  logic [PW-1:0] req_idx;
  logic          list_end, byte_taken;

  assign req_idx    = PW'(prog_num - 8'd1);
  assign list_end   = (rec_q == SW'(NREC)) || is_term(rec_in);
  assign byte_taken = (st == S_SEND) && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      prog_q   <= '0;
      rec_q    <= '0;
      cur_addr <= '0;
      left     <= '0;
      byte_q   <= '0;
      err_q    <= ERR_NONE;
      emitted  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          emitted <= '0;
          rec_q   <= '0;
          prog_q  <= req_idx;
          if (!num_ok(prog_num, NPROG)) begin
            err_q <= ERR_RANGE;
            st    <= S_DONE;
          end else if (!ok_vec[req_idx]) begin
            err_q <= ERR_SIZE;
            st    <= S_DONE;
          end else begin
            err_q <= ERR_NONE;
            st    <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (list_end) begin
            st <= S_DONE;
          end else begin
            rec_q <= rec_q + SW'(1);
            if (rec_in.cnt != 16'd0) begin
              cur_addr <= rec_in.addr;
              left     <= rec_in.cnt;
              st       <= S_REQ;
            end
          end
        end
        S_REQ: if (mem_rvalid) begin
          byte_q <= mem_rdata;
          st     <= S_SEND;
        end
        S_SEND: if (out_ready) begin
          emitted  <= emitted + 16'd1;
          cur_addr <= cur_addr + 16'd1;
          left     <= left - 16'd1;
          st       <= (left == 16'd1) ? S_LOOK : S_REQ;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rd_prog   = prog_q;
  assign rd_slot   = rec_q;
  assign mem_req   = (st == S_REQ);
  assign mem_addr  = cur_addr;
  assign out_valid = (st == S_SEND);
  assign out_data  = byte_q;
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign err       = err_q;

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  assert_one_byte_per_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_taken |=> !out_valid);

  assert_total_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    emitted <= 16'(MAX_TOTAL));

  assert_no_flagged_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ok_vec[prog_q]);

endmodule

// File: rtl/scatter_read_seq.sv
module scatter_read_seq
  import seqp_pkg::*;
#(
  parameter int NPROG     = 10,
  parameter int NREC      = 25,
  parameter int MAX_TOTAL = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_valid,
  input  logic       ld_sof,
  input  logic [7:0] ld_byte,
  output logic       ld_done,
  output logic [1:0] ld_err,
  input  logic       ex_start,
  input  logic [7:0] ex_prog,
  output logic       ex_busy,
  output logic       ex_done,
  output logic [1:0] ex_err,
  output logic       mem_req,
  output logic [15:0] mem_addr,
  input  logic       mem_rvalid,
  input  logic [7:0] mem_rdata,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready
);

  localparam int PW = $clog2(NPROG);
  localparam int SW = $clog2(NREC + 1);

  logic             wr_en, ok_we, ok_val;
  logic [PW-1:0]    wr_prog, ok_prog, rd_prog;
  logic [SW-1:0]    wr_slot, rd_slot;
  rec_t             wr_rec, rd_rec;
  logic [NPROG-1:0] ok_vec;

  seqp_loader #(.NPROG(NPROG), .NREC(NREC), .MAX_TOTAL(MAX_TOTAL)) u_loader (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_sof(ld_sof), .ld_byte(ld_byte),
    .wr_en(wr_en), .wr_prog(wr_prog), .wr_slot(wr_slot), .wr_rec(wr_rec),
    .ok_we(ok_we), .ok_prog(ok_prog), .ok_val(ok_val),
    .ld_done(ld_done), .ld_err(ld_err)
  );

  seqp_store #(.NPROG(NPROG), .NREC(NREC)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_prog(wr_prog), .wr_slot(wr_slot), .wr_rec(wr_rec),
    .ok_we(ok_we), .ok_prog(ok_prog), .ok_val(ok_val),
    .rd_prog(rd_prog), .rd_slot(rd_slot), .rd_rec(rd_rec),
    .ok_vec(ok_vec)
  );

  seqp_exec #(.NPROG(NPROG), .NREC(NREC), .MAX_TOTAL(MAX_TOTAL)) u_exec (
    .clk(clk), .rst_n(rst_n),
    .start(ex_start), .prog_num(ex_prog), .ok_vec(ok_vec),
    .rd_prog(rd_prog), .rd_slot(rd_slot), .rec_in(rd_rec),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .busy(ex_busy), .done(ex_done), .err(ex_err)
  );

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ex_done |-> (!out_valid && !mem_req));

endmodule

// File: tb/scatter_read_seq_bench.sv
module scatter_read_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 9;

  // {program number, 2'b00, expected load code, four records of {addr, count}}
  localparam logic [139:0] VEC [NVEC] = '{
    {8'h01, 4'd0, 32'h0005_0007, 32'h004B_0003, 32'h0138_0011, 32'hFFFF_FFFF}, // R4 three ranges
    {8'h0A, 4'd0, 32'h0064_0004, 32'h0064_0004, 32'hFFFF_0000, 32'h0000_0009}, // R4 repeat, R3
    {8'h02, 4'd0, 32'hFFFF_0003, 32'h0010_0900, 32'h0000_0000, 32'h0000_0000}, // R6 empty, R3
    {8'h03, 4'd0, 32'h000A_0000, 32'h0014_0002, 32'hFFFF_1234, 32'h001E_0005}, // R7, R3
    {8'h04, 4'd0, 32'h0000_0800, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF}, // R5 exactly 2048
    {8'h05, 4'd2, 32'h0000_07D0, 32'h0100_0031, 32'hFFFF_FFFF, 32'hFFFF_FFFF}, // R5 2049
    {8'h00, 4'd1, 32'h0001_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF}, // R1 zero
    {8'h0B, 4'd1, 32'h0001_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF}, // R1 eleven
    {8'h01, 4'd0, 32'h00C8_0002, 32'h1234_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF}  // R11 reload
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_valid = 1'b0, ld_sof = 1'b0;
  logic [7:0] ld_byte = 8'h00;
  logic       ld_done;
  logic [1:0] ld_err;
  logic       ex_start = 1'b0;
  logic [7:0] ex_prog = 8'h00;
  logic       ex_busy, ex_done;
  logic [1:0] ex_err;
  logic       mem_req;
  logic [15:0] mem_addr;
  logic       mem_rvalid;
  logic [7:0] mem_rdata;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b1;

  int  checks = 0;
  int  fails = 0;
  int  cyc = 0;
  int  resp_cnt = 0;
  bit  slow_mode = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  scatter_read_seq u_scatter_read_seq (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_sof(ld_sof), .ld_byte(ld_byte),
    .ld_done(ld_done), .ld_err(ld_err),
    .ex_start(ex_start), .ex_prog(ex_prog),
    .ex_busy(ex_busy), .ex_done(ex_done), .ex_err(ex_err),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  function automatic logic [7:0] mdat(input logic [15:0] a);
    return 8'(a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
  endfunction

  // memory model: answers one cycle after a request, one answer per request
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= 8'h00;
    end else begin
      mem_rvalid <= mem_req && !mem_rvalid;
      mem_rdata  <= mdat(mem_addr);
      if (mem_rvalid) resp_cnt <= resp_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load_prog(input logic [7:0] pn, input logic [127:0] recs,
                           input logic [1:0] exp_err, input string req);
    for (int i = 0; i < 104; i++) begin
      logic [7:0] b;
      int slot;
      int fld;
      logic [31:0] r;
      slot = (i - 2) / 4;
      fld  = (i - 2) % 4;
      if (i == 0)       b = 8'h5C;
      else if (i == 1)  b = pn;
      else if (i >= 102) b = 8'hFF;
      else if (slot < 4) begin
        r = recs[127 - 32 * slot -: 32];
        case (fld)
          0: b = r[23:16];
          1: b = r[31:24];
          2: b = r[7:0];
          default: b = r[15:8];
        endcase
      end else b = 8'hFF;
      ld_valid = 1'b1;
      ld_sof   = (i == 0);
      ld_byte  = b;
      @(negedge clk);
      if (i < 103) chk(!ld_done, "R2", "ld_done early", int'(ld_done), 0);
    end
    ld_valid = 1'b0;
    ld_sof   = 1'b0;
    chk(ld_done == 1'b1, "R2", "ld_done after byte 103", int'(ld_done), 1);
    chk(ld_err == exp_err, req, "ld_err", int'(ld_err), int'(exp_err));
    @(negedge clk);
    chk(!ld_done, "R2", "ld_done one cycle", int'(ld_done), 0);
  endtask

  task automatic run_prog(input logic [7:0] pn, input logic [127:0] recs,
                          input logic [1:0] exp_err, input string req);
    logic [7:0] expb [2100];
    int nexp = 0;
    int got = 0;
    int bad = 0;
    int stall_bad = 0;
    int guard = 0;
    int resp0;
    bit prev_stall = 1'b0;
    logic [7:0] prev_d = 8'h00;
    logic [1:0] err_seen = 2'd3;
    if (exp_err == 2'd0) begin
      for (int r = 0; r < 4; r++) begin
        logic [15:0] a;
        logic [15:0] c;
        a = recs[127 - 32 * r -: 16];
        c = recs[111 - 32 * r -: 16];
        if (a == 16'hFFFF) break;
        for (int j = 0; j < int'(c); j++)
          if (nexp < 2100) begin
            expb[nexp] = mdat(a + 16'(j));
            nexp++;
          end
      end
    end
    resp0 = resp_cnt;
    ex_prog  = pn;
    ex_start = 1'b1;
    @(negedge clk);
    ex_start = 1'b0;
    while (1) begin
      out_ready = slow_mode ? (guard[0] ^ guard[2]) : 1'b1;
      if (prev_stall && (!out_valid || out_data != prev_d)) stall_bad++;
      if (ex_done) begin
        err_seen = ex_err;
        break;
      end
      if (out_valid && out_ready) begin
        if (got >= nexp || out_data != expb[got]) begin
          if (bad == 0)
            $display("FAIL %s byte %0d: actual %0d expected %0d", req, got,
                     out_data, (got < nexp) ? int'(expb[got]) : -1);
          bad++;
        end
        got++;
      end
      prev_stall = out_valid && !out_ready;
      prev_d     = out_data;
      guard++;
      if (guard > 20000) break;
      @(negedge clk);
    end
    out_ready = 1'b1;
    chk(err_seen == exp_err, req, "ex_err", int'(err_seen), int'(exp_err));
    chk(got == nexp, req, "byte count", got, nexp);
    chk(bad == 0, "R4", "stream mismatches", bad, 0);
    chk(stall_bad == 0, "R9", "held byte changed", stall_bad, 0);
    chk(resp_cnt - resp0 == nexp, "R10", "memory requests", resp_cnt - resp0, nexp);
    @(negedge clk);
    chk(!ex_busy && !ex_done, "R6", "idle after done", int'(ex_busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: idle outputs after reset, every program empty
    chk(!ex_busy && !ex_done && !ld_done, "R8", "control outputs", int'(ex_busy | ex_done | ld_done), 0);
    chk(!mem_req && !out_valid, "R8", "datapath outputs", int'(mem_req | out_valid), 0);
    run_prog(8'h07, {4{32'hFFFF_FFFF}}, 2'd0, "R8");
    run_prog(8'h0A, {4{32'hFFFF_FFFF}}, 2'd0, "R8");

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      slow_mode = v[0];
      load_prog(VEC[v][139:132], VEC[v][127:0], VEC[v][129:128], "R1/R2/R5 load");
      run_prog(VEC[v][139:132], VEC[v][127:0], VEC[v][129:128], "R1/R3/R5/R6/R7 run");
    end

    // R1: loads with bad numbers left program 3 and program 10 intact
    slow_mode = 1'b1;
    run_prog(8'h03, VEC[3][127:0], 2'd0, "R1 no clobber");
    run_prog(8'h0A, VEC[1][127:0], 2'd0, "R1 no clobber");
    // R1: run request with an out-of-range number
    run_prog(8'h0C, VEC[0][127:0], 2'd1, "R1 run range");
    run_prog(8'hFF, VEC[0][127:0], 2'd1, "R1 run range");
    // R11: oversized reload of a runnable program
    slow_mode = 1'b0;
    load_prog(8'h0A, {32'h0000_0BB8, {3{32'hFFFF_FFFF}}}, 2'd2, "R11 load");
    run_prog(8'h0A, {32'h0000_0BB8, {3{32'hFFFF_FFFF}}}, 2'd2, "R11 run");
    // R11: and a legal reload makes it runnable again
    load_prog(8'h0A, {32'h0300_0005, {3{32'hFFFF_FFFF}}}, 2'd0, "R11 load");
    run_prog(8'h0A, {32'h0300_0005, {3{32'hFFFF_FFFF}}}, 2'd0, "R11 run");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule